// File: doc/BRIEF.md
# Ship Mode Controller

This block decides when a battery-powered system drops into its deepest shipping state, where nearly everything is switched off, and when it comes back out. It watches digitized comparator flags for the input supply, a chip-disable level, an active-low push-button and a software request bit. From these it drives a power-down request, a wake (power-up) request, and a status that tells the host when the serial bus may be used.

Entry needs a pending request and three conditions held steady for a quiet interval: no input supply, chip-disable high and the button released. A request comes from a register strobe or, when the long-press config bit is 0, from holding the button for the reset interval. A request made while the supply is present stays pending until the supply goes away. There are two ways out of ship mode. Plugging in an adapter wakes the block at once. Holding the button for the wake interval also wakes it, provided the battery is healthy and no supply is present. All intervals are parameters counted in clock cycles, and every asynchronous input passes through a synchronizer.

Top module: `ship_mode_ctrl`

## Requirements
- R1: After synchronous reset: `hostBusOk`=1, `shipPowerDown`=0, `wakeReq`=0, and no request is pending. Ship mode is never entered while `vinPresent` is 1.
- R2: With a request pending, `vinPresent`=0, `chipDisable`=1 and `buttonN`=1 held for QUIET_CYC cycles, `shipPowerDown` goes to 1 and `hostBusOk` goes to 0. With `chipDisable`=0 there is no entry.
- R3: A `shipReqSet` pulse while `vinPresent`=1 stays pending. Entry happens after `vinPresent` later falls, with no further pulse needed.
- R4: A `shipReqClr` pulse while `vinPresent`=1 cancels a pending register request. The same pulse while `vinPresent`=0 is ignored.
- R5: If any entry condition drops during the quiet interval, the attempt is aborted. A full QUIET_CYC interval is timed again from the moment the conditions return.
- R6: Holding `buttonN`=0 for RESET_CYC cycles outside ship mode creates a request when `longPressCfg`=0. With `longPressCfg`=1 it has no effect.
- R7: In ship mode, `vinAboveBat`=1 returns the block to active (`hostBusOk`=1). This path wins if the button falls in the same cycle.
- R8: In ship mode, with `batAboveUvlo`=1 and `vinPresent`=0, a falling `buttonN` raises `wakeReq` at once. Holding it for WAKE_CYC cycles completes the exit. Releasing it earlier returns to ship mode. With `batAboveUvlo`=0 the button is ignored.
- R9: `hostBusOk` is 1 only in the active and quiet states. It is 0 in ship mode and while waking.
- R10: A long-press request that is still held low when an adapter connects does not cause entry while the adapter is present. It stays pending and is acted on after the adapter is removed and the button is released.
- R11: A long-press request is dropped if the adapter connects after the button has been released. It is also dropped if the button stays low for WAKE_CYC cycles while the adapter is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vinPresent | input | 1 | Input supply above its undervoltage level (async) |
| vinAboveBat | input | 1 | Input above battery plus sleep margin (async) |
| batAboveUvlo | input | 1 | Battery above highest undervoltage threshold (async) |
| chipDisable | input | 1 | Chip-disable level (async) |
| buttonN | input | 1 | Push-button, active low (async) |
| shipReqSet | input | 1 | Register strobe requesting ship mode |
| shipReqClr | input | 1 | Register strobe clearing the request |
| longPressCfg | input | 1 | 0: long press requests ship mode |
| shipPowerDown | output | 1 | Ship-mode power-down request |
| wakeReq | output | 1 | Power-up request during button wake |
| hostBusOk | output | 1 | Host may use the serial bus |

## Verification
In ship mode, adapter arrival and a button press can be seen in the same cycle. A directed test lowers the button and raises both supply flags on the same clock, so both pass through the synchronizers together and reach the state machine in one cycle. The bench expects `wakeReq` to stay 0 and `hostBusOk` to return to 1, which shows that the adapter path takes priority. A second overlap is a long-press expiry racing an adapter connection. This is checked by holding the button low across the adapter's arrival and later judging whether entry happens after the adapter is removed.

// File: rtl/ship_mode_pkg.sv
package ship_mode_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_QUIET  = 2'd1,
    ST_SHIP   = 2'd2,
    ST_WAKING = 2'd3
  } shipState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic intClr;   // clear the interval counter
    logic intRun;   // advance the interval counter
    logic pressEn;  // button timing and register requests accepted
    logic reqTake;  // entry happened: drop all pending requests
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic vinS;
    logic aboveS;
    logic batS;
    logic cdS;
    logic btnLowS;
    logic pendReq;
    logic quietDone;
    logic wakeDone;
  } dpStatus_t;

endpackage

// File: rtl/ship_mode_sync.sv
module ship_mode_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
    end else begin
      pipe[0] <= din;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/ship_mode_dp.sv
module ship_mode_dp
  import ship_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUIET_CYC = 8,
  parameter int WAKE_CYC = 6,
  parameter int RESET_CYC = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        vinPresent,
  input  logic        vinAboveBat,
  input  logic        batAboveUvlo,
  input  logic        chipDisable,
  input  logic        buttonN,
  input  logic        shipReqSet,
  input  logic        shipReqClr,
  input  logic        longPressCfg,
  input  ctrlStrobe_t strb,
  output dpStatus_t   sts
);

  localparam int INT_MAX = (QUIET_CYC > WAKE_CYC) ? QUIET_CYC : WAKE_CYC;
  localparam int INT_W = $clog2(INT_MAX + 1);
  localparam int PRESS_W = $clog2(RESET_CYC + 1);
  localparam int HOLD_W = $clog2(WAKE_CYC + 1);
  localparam int NUM_IN = 5;
  localparam logic [NUM_IN-1:0] SYNC_RST = 5'b00001;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncIn;
  logic vinS, aboveS, batS, cdS, btnLowS;

  assign rawIn = {vinPresent, vinAboveBat, batAboveUvlo, chipDisable, buttonN};

  ship_mode_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (NUM_IN),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rawIn),
    .dout(syncIn)
  );

  assign vinS    = syncIn[4];
  assign aboveS  = syncIn[3];
  assign batS    = syncIn[2];
  assign cdS     = syncIn[1];
  assign btnLowS = ~syncIn[0];

  // shared quiet / wake interval counter
  logic [INT_W-1:0] intCnt;
  always_ff @(posedge clk) begin
    if (rst || strb.intClr) intCnt <= '0;
    else if (strb.intRun && intCnt != INT_W'(INT_MAX)) intCnt <= intCnt + 1'b1;
  end

  logic quietDone, wakeDone;
  assign quietDone = strb.intRun && (intCnt == INT_W'(QUIET_CYC - 1));
  assign wakeDone  = strb.intRun && (intCnt == INT_W'(WAKE_CYC - 1));

  // long-press timer
  logic [PRESS_W-1:0] pressCnt;
  logic pressExpired;
  always_ff @(posedge clk) begin
    if (rst || !strb.pressEn || !btnLowS) pressCnt <= '0;
    else if (pressCnt != PRESS_W'(RESET_CYC)) pressCnt <= pressCnt + 1'b1;
  end
  assign pressExpired = strb.pressEn && btnLowS && (pressCnt == PRESS_W'(RESET_CYC - 1));

  // pending requests
  logic regReq, pressReq, vinPrev, vinRise;
  logic [HOLD_W-1:0] holdCnt;
  logic holdActive, holdExceeded;

  always_ff @(posedge clk) begin
    if (rst) vinPrev <= 1'b0;
    else vinPrev <= vinS;
  end
  assign vinRise = vinS && !vinPrev;

  assign holdActive = vinS && btnLowS && pressReq;
  always_ff @(posedge clk) begin
    if (rst || !holdActive) holdCnt <= '0;
    else if (holdCnt != HOLD_W'(WAKE_CYC)) holdCnt <= holdCnt + 1'b1;
  end
  assign holdExceeded = holdActive && (holdCnt == HOLD_W'(WAKE_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) regReq <= 1'b0;
    else if (strb.reqTake) regReq <= 1'b0;
    else if (shipReqSet && strb.pressEn) regReq <= 1'b1;
    else if (shipReqClr && vinS) regReq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) pressReq <= 1'b0;
    else if (strb.reqTake) pressReq <= 1'b0;
    else if (pressExpired && !longPressCfg) pressReq <= 1'b1;
    else if (holdExceeded) pressReq <= 1'b0;
    else if (vinRise && !btnLowS) pressReq <= 1'b0;
  end

  assign sts = '{
    vinS:      vinS,
    aboveS:    aboveS,
    batS:      batS,
    cdS:       cdS,
    btnLowS:   btnLowS,
    pendReq:   regReq | pressReq,
    quietDone: quietDone,
    wakeDone:  wakeDone
  };

  AST_INT_BOUND: assert property (@(posedge clk) disable iff (rst)
    intCnt <= INT_W'(INT_MAX)) else $error("interval counter overran"); // R5
  AST_CLR_NEEDS_VIN: assert property (@(posedge clk) disable iff (rst)
    $fell(regReq) |-> ($past(strb.reqTake) || $past(vinS)))
    else $error("register request dropped without supply"); // R4
  AST_PRESS_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(pressReq) |-> $past(!longPressCfg))
    else $error("long press accepted while disabled"); // R6

endmodule

// File: rtl/ship_mode_fsm.sv
module ship_mode_fsm
  import ship_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  dpStatus_t   sts,
  output ctrlStrobe_t strb,
  output logic        shipPowerDown,
  output logic        wakeReq,
  output logic        hostBusOk
);

  shipState_t stateQ, stateD;
  logic entryOk;

  assign entryOk = sts.pendReq && !sts.vinS && sts.cdS && !sts.btnLowS;

  always_comb begin
    stateD = stateQ;
    strb = '0;
    unique case (stateQ)
      ST_ACTIVE: begin
        strb.intClr = 1'b1;
        strb.pressEn = 1'b1;
        if (entryOk) stateD = ST_QUIET;
      end
      ST_QUIET: begin
        strb.intRun = 1'b1;
        strb.pressEn = 1'b1;
        if (!entryOk) begin
          stateD = ST_ACTIVE;
        end else if (sts.quietDone) begin
          stateD = ST_SHIP;
          strb.reqTake = 1'b1;
        end
      end
      ST_SHIP: begin
        strb.intClr = 1'b1;
        if (sts.aboveS) stateD = ST_ACTIVE;
        else if (sts.btnLowS && sts.batS && !sts.vinS) stateD = ST_WAKING;
      end
      ST_WAKING: begin
        strb.intRun = 1'b1;
        if (sts.aboveS) stateD = ST_ACTIVE;
        else if (!sts.btnLowS) stateD = ST_SHIP;
        else if (sts.wakeDone) stateD = ST_ACTIVE;
      end
      default: stateD = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_ACTIVE;
    else stateQ <= stateD;
  end

  assign shipPowerDown = (stateQ == ST_SHIP);
  assign wakeReq       = (stateQ == ST_WAKING);
  assign hostBusOk     = (stateQ == ST_ACTIVE) || (stateQ == ST_QUIET);

  AST_ENTRY_NO_VIN: assert property (@(posedge clk) disable iff (rst)
    $rose(shipPowerDown) |-> $past(!sts.vinS && sts.cdS))
    else $error("entry with supply present"); // R1
  AST_ENTRY_AFTER_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($rose(shipPowerDown) && $past(hostBusOk)) |-> $past(sts.quietDone))
    else $error("entry before quiet interval"); // R5
  AST_WAKE_BAT_OK: assert property (@(posedge clk) disable iff (rst)
    $rose(wakeReq) |-> $past(sts.batS && sts.btnLowS))
    else $error("wake without healthy battery"); // R8
  AST_ADAPTER_EXIT: assert property (@(posedge clk) disable iff (rst)
    ($past(shipPowerDown) && $past(sts.aboveS)) |-> hostBusOk)
    else $error("adapter did not wake"); // R7
  AST_BUS_GATED: assert property (@(posedge clk) disable iff (rst)
    hostBusOk |-> (!shipPowerDown && !wakeReq))
    else $error("bus allowed while down"); // R9
  AST_OUT_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({shipPowerDown, wakeReq, hostBusOk}))
    else $error("outputs overlap"); // R9

endmodule

// File: rtl/ship_mode_ctrl.sv
module ship_mode_ctrl
  import ship_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUIET_CYC = 2000,
  parameter int WAKE_CYC = 50000,
  parameter int RESET_CYC = 400000
) (
  input  logic clk,
  input  logic rst,
  input  logic vinPresent,
  input  logic vinAboveBat,
  input  logic batAboveUvlo,
  input  logic chipDisable,
  input  logic buttonN,
  input  logic shipReqSet,
  input  logic shipReqClr,
  input  logic longPressCfg,
  output logic shipPowerDown,
  output logic wakeReq,
  output logic hostBusOk
);

  ctrlStrobe_t strb;
  dpStatus_t sts;

  ship_mode_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .QUIET_CYC  (QUIET_CYC),
    .WAKE_CYC   (WAKE_CYC),
    .RESET_CYC  (RESET_CYC)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .vinPresent  (vinPresent),
    .vinAboveBat (vinAboveBat),
    .batAboveUvlo(batAboveUvlo),
    .chipDisable (chipDisable),
    .buttonN     (buttonN),
    .shipReqSet  (shipReqSet),
    .shipReqClr  (shipReqClr),
    .longPressCfg(longPressCfg),
    .strb        (strb),
    .sts         (sts)
  );

  ship_mode_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .sts          (sts),
    .strb         (strb),
    .shipPowerDown(shipPowerDown),
    .wakeReq      (wakeReq),
    .hostBusOk    (hostBusOk)
  );

endmodule

// File: tb/ship_mode_ctrl_tb.sv
`timescale 1ns/1ps
module ship_mode_ctrl_tb;

  localparam int QUIET = 8;
  localparam int WAKE = 6;
  localparam int RSTI = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vin = 1'b1, vab = 1'b1, bat = 1'b1, cd = 1'b1, btn = 1'b1;
  logic setS = 1'b0, clrS = 1'b0, cfg = 1'b1;
  logic shipPowerDown, wakeReq, hostBusOk;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ship_mode_ctrl #(
    .SYNC_STAGES(2), .QUIET_CYC(QUIET), .WAKE_CYC(WAKE), .RESET_CYC(RSTI)
  ) u_dut (
    .clk(clk), .rst(rst), .vinPresent(vin), .vinAboveBat(vab),
    .batAboveUvlo(bat), .chipDisable(cd), .buttonN(btn),
    .shipReqSet(setS), .shipReqClr(clrS), .longPressCfg(cfg),
    .shipPowerDown(shipPowerDown), .wakeReq(wakeReq), .hostBusOk(hostBusOk)
  );

  typedef struct packed {
    logic vin, vab, bat, cd, btn, set, clr, cfg;
    logic [7:0] hold;
    logic eShip, eWake, eBus;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 8'd4,  1'b0,1'b0,1'b1, 4'd1},  // R1 idle
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 8'd20, 1'b0,1'b0,1'b1, 4'd3},  // R3 set with supply
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 8'd20, 1'b1,1'b0,1'b0, 4'd3},  // R3 enter on removal
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 8'd6,  1'b0,1'b0,1'b1, 4'd7},  // R7 adapter exit
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 8'd4,  1'b0,1'b0,1'b1, 4'd4},  // R4 set
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1, 8'd4,  1'b0,1'b0,1'b1, 4'd4},  // R4 clear
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 8'd20, 1'b0,1'b0,1'b1, 4'd4},  // R4 cancelled
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 8'd20, 1'b1,1'b0,1'b0, 4'd2},  // R2 entry
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 8'd4,  1'b0,1'b1,1'b0, 4'd8},  // R8 wake starts
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 8'd10, 1'b0,1'b0,1'b1, 4'd8},  // R8 wake done
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 8'd3,  1'b0,1'b0,1'b1, 4'd9},  // R9 active
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 8'd20, 1'b1,1'b0,1'b0, 4'd2},  // R2 re-entry
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 8'd4,  1'b0,1'b1,1'b0, 4'd9},  // R9 waking no bus
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 8'd6,  1'b1,1'b0,1'b0, 4'd8},  // R8 early release
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 8'd8,  1'b1,1'b0,1'b0, 4'd8},  // R8 low battery
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 8'd6,  1'b0,1'b0,1'b1, 4'd7},  // R7 adapter exit
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1, 8'd20, 1'b0,1'b0,1'b1, 4'd2},  // R2 cd low blocks
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 8'd20, 1'b1,1'b0,1'b0, 4'd2},  // R2 cd high enters
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 8'd6,  1'b0,1'b0,1'b1, 4'd7},  // R7
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 8'd16, 1'b0,1'b0,1'b1, 4'd6},  // R6 cfg=1 press
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 8'd20, 1'b0,1'b0,1'b1, 4'd6},  // R6 no effect
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'd16, 1'b0,1'b0,1'b1, 4'd6},  // R6 cfg=0 press
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'd20, 1'b1,1'b0,1'b0, 4'd6},  // R6 entry
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 8'd6,  1'b0,1'b0,1'b1, 4'd7}   // R7
  };

  task automatic check(input int req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input int req, input logic eShip, input logic eWake, input logic eBus);
    check(req, "shipPowerDown", shipPowerDown, eShip);
    check(req, "wakeReq", wakeReq, eWake);
    check(req, "hostBusOk", hostBusOk, eBus);
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input logic v, input logic a, input logic b, input logic c,
                       input logic p, input logic g);
    vin = v; vab = a; bat = b; cd = c; btn = p; cfg = g;
  endtask

  task automatic pulseSet();
    setS = 1'b1; @(negedge clk); setS = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    waitN(4);
    rst = 1'b0;
    waitN(1);
    checkAll(1, 1'b0, 1'b0, 1'b1);  // R1 reset state

    for (int k = 0; k < NV; k++) begin
      vin = VECS[k].vin; vab = VECS[k].vab; bat = VECS[k].bat;
      cd = VECS[k].cd; btn = VECS[k].btn; cfg = VECS[k].cfg;
      setS = VECS[k].set; clrS = VECS[k].clr;
      @(negedge clk);
      setS = 1'b0; clrS = 1'b0;
      waitN(int'(VECS[k].hold) - 1);
      checkAll(int'(VECS[k].req), VECS[k].eShip, VECS[k].eWake, VECS[k].eBus);
    end

    // R5: drop chip-disable mid-quiet, full interval retimed
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    waitN(4);
    pulseSet();
    waitN(3);
    cd = 1'b0;
    waitN(3);
    check(5, "aborted quiet", shipPowerDown, 1'b0);
    cd = 1'b1;
    waitN(8);
    check(5, "retimed quiet not early", shipPowerDown, 1'b0);
    waitN(6);
    check(5, "retimed quiet entry", shipPowerDown, 1'b1);

    // R7: adapter and button fall in the same cycle, adapter wins
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    waitN(4);
    checkAll(7, 1'b0, 1'b0, 1'b1);
    btn = 1'b1;
    waitN(4);

    // R4: clear while supply absent is ignored
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    waitN(4);
    pulseSet();
    clrS = 1'b1; @(negedge clk); clrS = 1'b0;
    cd = 1'b1;
    waitN(20);
    check(4, "clear ignored without supply", shipPowerDown, 1'b1);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    waitN(6);

    // R10: long press, adapter arrives while still held
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    waitN(RSTI + 4);
    vin = 1'b1; vab = 1'b1;
    waitN(3);
    btn = 1'b1;
    waitN(20);
    checkAll(10, 1'b0, 1'b0, 1'b1);
    vin = 1'b0; vab = 1'b0;
    waitN(20);
    check(10, "entry after adapter removed", shipPowerDown, 1'b1);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    waitN(6);

    // R11: adapter connects after release, request dropped
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    waitN(RSTI + 4);
    btn = 1'b1;
    waitN(4);
    vin = 1'b1; vab = 1'b1;
    waitN(6);
    vin = 1'b0; vab = 1'b0;
    waitN(20);
    checkAll(11, 1'b0, 1'b0, 1'b1);

    // R11: button held past the wake interval with adapter present
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    waitN(RSTI + 4);
    vin = 1'b1; vab = 1'b1;
    waitN(WAKE + 8);
    btn = 1'b1;
    waitN(4);
    vin = 1'b0; vab = 1'b0;
    waitN(20);
    checkAll(11, 1'b0, 1'b0, 1'b1);

    // R1: reset out of ship mode
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    pulseSet();
    waitN(20);
    check(2, "setup entry", shipPowerDown, 1'b1);
    rst = 1'b1;
    waitN(2);
    rst = 1'b0;
    waitN(1);
    checkAll(1, 1'b0, 1'b0, 1'b1);
    waitN(20);
    check(1, "no pending after reset", shipPowerDown, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule